// File: doc/BRIEF.md
# Processor Idle Clock Gate

This block decides, cycle by cycle, whether the processor core receives its clock. Software parks the core in an idle mode by pulsing a write-one stop strobe. The gate does not cut the clock at once. It waits until the core reports that the instruction in flight has retired, and only then drops the clock enable. Software can pulse a write-one start strobe to resume the core. Any interrupt request whose enable mask bit is set also resumes it, on either the normal or the fast request group.

The gate acts only on the core's clock enable. The system clock and the bus fabric keep running, so other bus masters go on moving data while the core is idle. The clock enable comes straight from a state register and changes only on a system clock edge, so a downstream glitch-free gating cell never sees a shortened pulse. All pins are plain level or strobe control signals. No data flows through the block, so it has no valid/ready handshake.

Top module: `cpu_idle_gate`

## Requirements
- R1: After reset, `cpu_clk_en` is 1 and `clk_running` is 1.
- R2: A `stop_wr` pulse while running leaves `cpu_clk_en` at 1 for as long as `insn_done` stays 0 (the stop is held pending).
- R3: While a stop is pending, a cycle with `insn_done` = 1, no `start_wr` and no enabled interrupt makes `cpu_clk_en` 0 from the next cycle. `cpu_clk_en` never falls unless `insn_done` was 1 in the cycle before.
- R4: While idle, a cycle in which any bit of `irq_req & irq_en` or `fiq_req & fiq_en` is 1 makes `cpu_clk_en` 1 from the next cycle.
- R5: An interrupt request whose mask bit is 0 has no effect: the core stays idle.
- R6: An enabled interrupt seen while a stop is pending cancels the stop. A later `insn_done` then does not stop the clock.
- R7: A `start_wr` pulse while idle makes `cpu_clk_en` 1 from the next cycle.
- R8: When `start_wr` and `stop_wr` are both 1 in the same cycle, start wins. No stop is requested, and a pending stop is cancelled.
- R9: `clk_running` equals `cpu_clk_en` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (never gated by this block) |
| rst_n | input | 1 | Active-low synchronous reset |
| start_wr | input | 1 | Write-one strobe: run the core clock |
| stop_wr | input | 1 | Write-one strobe: request idle mode |
| insn_done | input | 1 | Core reports that the current instruction has retired |
| irq_req | input | N_IRQ | Normal interrupt requests, active high |
| irq_en | input | N_IRQ | Per-source enables for `irq_req` |
| fiq_req | input | N_FIQ | Fast interrupt requests, active high |
| fiq_en | input | N_FIQ | Per-source enables for `fiq_req` |
| cpu_clk_en | output | 1 | Registered enable for the core clock gating cell |
| clk_running | output | 1 | Status bit: 1 while the core clock runs |

## Verification
The assertions check four things on every cycle: the status bit tracks the enable, the enable only falls after a retired instruction, an enabled interrupt or a start strobe always wakes an idle core, and a start strobe paired with a stop strobe never lets the clock drop. The bench scenarios cover what needs a history to show. These are the clock holding through a pending stop, masked requests being ignored, a pending stop being cancelled by an interrupt or by a simultaneous start, and a later `insn_done` having no effect once the stop is cancelled.

// File: rtl/pig_pkg.sv
package pig_pkg;
  typedef enum logic [1:0] {
    GS_RUN  = 2'd0,
    GS_WAIT = 2'd1,
    GS_IDLE = 2'd2
  } gate_state_e;
endpackage

// File: rtl/pig_wake_merge.sv
module pig_wake_merge #(
  parameter int N_IRQ = 4,
  parameter int N_FIQ = 2
) (
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_FIQ-1:0] fiq_req,
  input  logic [N_FIQ-1:0] fiq_en,
  output logic             wake
);
  localparam int N_ALL = N_IRQ + N_FIQ;
  logic [N_ALL-1:0] hit;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    assign hit[i] = irq_req[i] & irq_en[i];
  end
  for (genvar j = 0; j < N_FIQ; j++) begin : g_fiq
    assign hit[N_IRQ+j] = fiq_req[j] & fiq_en[j];
  end

  assign wake = |hit;
endmodule

// File: rtl/pig_seq.sv
module pig_seq
  import pig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_wr,
  input  logic stop_wr,
  input  logic insn_done,
  input  logic wake,
  output logic run_q
);
  gate_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GS_RUN:  if (stop_wr && !start_wr) state_d = GS_WAIT;
      GS_WAIT: begin
        if (start_wr || wake)  state_d = GS_RUN;
        else if (insn_done)    state_d = GS_IDLE;
      end
      GS_IDLE: if (start_wr || wake) state_d = GS_RUN;
      default: state_d = GS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= GS_RUN;
      run_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      run_q   <= (state_d != GS_IDLE);
    end
  end
endmodule

// File: rtl/cpu_idle_gate.sv
module cpu_idle_gate #(
  parameter int N_IRQ = 4,
  parameter int N_FIQ = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  logic             stop_wr,
  input  logic             insn_done,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [N_FIQ-1:0] fiq_req,
  input  logic [N_FIQ-1:0] fiq_en,
  output logic             cpu_clk_en,
  output logic             clk_running
);
  logic wake;
  logic run_q;

  pig_wake_merge #(.N_IRQ(N_IRQ), .N_FIQ(N_FIQ)) u_wake (
    .irq_req(irq_req), .irq_en(irq_en),
    .fiq_req(fiq_req), .fiq_en(fiq_en),
    .wake(wake)
  );

  pig_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_wr(start_wr), .stop_wr(stop_wr),
    .insn_done(insn_done), .wake(wake),
    .run_q(run_q)
  );

  assign cpu_clk_en  = run_q;
  assign clk_running = run_q;
endmodule

// File: rtl/cpu_idle_gate_chk.sv
module cpu_idle_gate_chk #(
  parameter int N_IRQ = 4,
  parameter int N_FIQ = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_wr,
  input logic             stop_wr,
  input logic             insn_done,
  input logic [N_IRQ-1:0] irq_req,
  input logic [N_IRQ-1:0] irq_en,
  input logic [N_FIQ-1:0] fiq_req,
  input logic [N_FIQ-1:0] fiq_en,
  input logic             cpu_clk_en,
  input logic             clk_running
);
  logic any_wake;
  assign any_wake = (|(irq_req & irq_en)) || (|(fiq_req & fiq_en));

  p_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_running == cpu_clk_en);

  p_stop_after_retire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_clk_en) |-> $past(insn_done));

  p_irq_wakes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && any_wake) |=> cpu_clk_en);

  p_start_wakes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && start_wr) |=> cpu_clk_en);

  p_tie_start_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && start_wr && stop_wr) |=> cpu_clk_en);
endmodule

bind cpu_idle_gate cpu_idle_gate_chk #(.N_IRQ(N_IRQ), .N_FIQ(N_FIQ)) u_chk (.*);

// File: tb/cpu_idle_gate_tb_top.sv
`timescale 1ns/1ps
module cpu_idle_gate_tb_top;
  localparam int NI = 4;
  localparam int NF = 2;

  typedef struct {
    logic  en;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_wr = 1'b0, stop_wr = 1'b0, insn_done = 1'b0;
  logic [NI-1:0] irq_req = '0, irq_en = '0;
  logic [NF-1:0] fiq_req = '0, fiq_en = '0;
  logic cpu_clk_en, clk_running;

  int total = 0;
  int bad = 0;
  bit done_flag = 1'b0;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  cpu_idle_gate #(.N_IRQ(NI), .N_FIQ(NF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .stop_wr(stop_wr),
    .insn_done(insn_done), .irq_req(irq_req), .irq_en(irq_en),
    .fiq_req(fiq_req), .fiq_en(fiq_en),
    .cpu_clk_en(cpu_clk_en), .clk_running(clk_running)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected enable
  task automatic drive(input logic s, input logic p, input logic d,
                       input logic [NI-1:0] ir, input logic [NI-1:0] im,
                       input logic [NF-1:0] fr, input logic [NF-1:0] fm,
                       input logic exp_en, input string tag);
    exp_t e;
    @(negedge clk);
    start_wr = s; stop_wr = p; insn_done = d;
    irq_req = ir; irq_en = im; fiq_req = fr; fiq_en = fm;
    e.en = exp_en; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare after the edge that consumed the stimulus
  always @(posedge clk) begin
    #5;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(cpu_clk_en, e.en, e.tag);
      check(clk_running, e.en, {e.tag, " status R9"});
    end
  end

  initial begin
    int cyc = 0;
    while (!done_flag && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(cpu_clk_en, 1'b1, "R1 reset enable");
    check(clk_running, 1'b1, "R1 reset status");

    drive(0,0,0, 4'h0,4'h0, 2'h0,2'h0, 1, "R1 quiet run");
    drive(0,1,0, 4'h0,4'h0, 2'h0,2'h0, 1, "R2 stop held");
    drive(0,0,0, 4'h0,4'h0, 2'h0,2'h0, 1, "R2 still pending");
    drive(0,0,1, 4'h0,4'h0, 2'h0,2'h0, 0, "R3 retire stops");
    drive(0,0,0, 4'h0,4'h0, 2'h0,2'h0, 0, "R3 stays idle");
    drive(0,0,0, 4'h4,4'h0, 2'h0,2'h0, 0, "R5 masked irq");
    drive(0,0,0, 4'h0,4'h0, 2'h2,2'h1, 0, "R5 masked fiq");
    drive(0,0,0, 4'h2,4'h2, 2'h0,2'h0, 1, "R4 irq wake");
    drive(0,1,0, 4'h0,4'h0, 2'h0,2'h0, 1, "R2 stop again");
    drive(0,0,1, 4'h0,4'h0, 2'h0,2'h0, 0, "R3 retire stops");
    drive(0,0,0, 4'h0,4'h0, 2'h1,2'h1, 1, "R4 fiq wake");
    drive(0,1,0, 4'h0,4'h0, 2'h0,2'h0, 1, "R2 stop pending");
    drive(0,0,0, 4'h8,4'h8, 2'h0,2'h0, 1, "R6 irq cancels");
    drive(0,0,1, 4'h0,4'h0, 2'h0,2'h0, 1, "R6 retire ignored");
    drive(0,1,0, 4'h0,4'h0, 2'h0,2'h0, 1, "R2 stop pending");
    drive(0,0,1, 4'h0,4'h0, 2'h0,2'h0, 0, "R3 retire stops");
    drive(1,0,0, 4'h0,4'h0, 2'h0,2'h0, 1, "R7 start restarts");
    drive(1,1,0, 4'h0,4'h0, 2'h0,2'h0, 1, "R8 tie in run");
    drive(0,0,1, 4'h0,4'h0, 2'h0,2'h0, 1, "R8 no stop after tie");
    drive(0,1,0, 4'h0,4'h0, 2'h0,2'h0, 1, "R2 stop pending");
    drive(1,1,0, 4'h0,4'h0, 2'h0,2'h0, 1, "R8 tie cancels pending");
    drive(0,0,1, 4'h0,4'h0, 2'h0,2'h0, 1, "R8 retire ignored");
    drive(0,0,0, 4'h0,4'h0, 2'h0,2'h0, 1, "R1 quiet run");

    repeat (3) @(posedge clk);
    done_flag = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule